// File: doc/BRIEF.md
# Thirty-Two Pin Register-Mapped GPIO Controller

This block controls 32 general-purpose pins through a small register bus. Each access moves one 32-bit word. Software picks a level and a drive enable for every pin. For each pin, a two-bit code in a value selector and a separate two-bit code in an enable selector choose one of two kinds of source:

- the block's own data and drive registers, or
- one of three alternate-function sources that reach the block on ports.

A per-pin open-drain switch turns the selected value into a pull-low-only drive. The pin levels pass through a two-flop synchronizer, and software reads them back as one word. The block also holds three receive words and six input-select words as plain read/write storage for neighbouring logic.

Pins are numbered from the most significant end. In every one-bit-per-pin word, and on the `pin_*` ports, pin n is bit 31−n.

Top module: `gpio_port_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, every register reads as zero and `pin_oe` is all zeros. In that state every pin floats, every select code is 00 and open-drain is off.
- R2: Pins are numbered MSB-first. In the data, drive, open-drain and level words, and on `pin_out`, `pin_oe` and `pin_in`, pin n occupies bit 31−n (mask 0x80000000 >> n).
- R3: The word index is `bus_addr[6:2]` and the low two address bits are ignored. The word offsets are: 0x00 data, 0x04 drive, 0x08 value-select low, 0x0C value-select high, 0x10 enable-select low, 0x14 enable-select high, 0x18 open-drain, 0x1C level, 0x20/0x24/0x28 receive 1..3, 0x2C gap, 0x30..0x44 input-select 1 low, 1 high, 2 low, 2 high, 3 low, 3 high. A write with `bus_wr` high lands at the clock edge. `bus_rdata` combinationally shows the word at `bus_addr`.
- R4: With both select codes at 00 and open-drain off, `pin_oe` equals the drive bit, where 1 drives and 0 floats, and `pin_out` equals the data bit.
- R5: Value-select fields are two bits per pin. Pins 0..15 sit in the low word and pins 16..31 in the high word, under mask 0xC0000000 >> 2·(n mod 16). Code 00 picks the data bit. Codes 01, 10 and 11 pick `alt_val[0]`, `alt_val[1]` and `alt_val[2]` at the pin's bit.
- R6: Enable-select fields use the same layout. Code 00 picks the drive bit. Codes 01, 10 and 11 pick `alt_en[0]`, `alt_en[1]` and `alt_en[2]`.
- R7: With the open-drain bit at 1, `pin_out` is 0. `pin_oe` is 1 only when the selected enable is 1 and the selected value is 0. With the open-drain bit at 0, the pin is push-pull.
- R8: The level word at 0x1C returns `pin_in` as it was sampled two clock edges earlier. Writes to it are ignored.
- R9: The gap word at 0x2C and every index from 18 upward read as zero. Writes to them are ignored and change no other word.
- R10: Writes to one word leave every other word unchanged. There is no atomic bit set or bit clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | ADDR_W (7) | Byte address; bits [1:0] ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the word at `bus_addr` |
| alt_val | input | 3×32 | Value from alternate sources 1..3 (codes 01..11) |
| alt_en | input | 3×32 | Enable from alternate sources 1..3 (codes 01..11) |
| pin_in | input | 32 | Pin levels, pin n on bit 31−n |
| pin_out | output | 32 | Pin output values |
| pin_oe | output | 32 | Pin output enables, 1 = driven |

## Verification
The level-lag property assumes `pin_in` changes only between clock edges. It counts the lag from two edges after reset release. The bench drives every input on the falling edge, so these assumptions hold.

The write property assumes that a write is a single-cycle strobe with stable address and data at the edge. The bench's bus task provides exactly that.

The alternate value and enable ports are treated as arbitrary, but they are held steady through each cycle. The bench varies them only between cycles.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int DATA_W    = 32;
    localparam int NUM_PINS  = 32;
    localparam int SEL_W     = 2;
    localparam int NUM_ALT   = 3;
    localparam int NUM_WORDS = 18;
    localparam int HALF_PINS = NUM_PINS / 2;

    typedef enum logic [4:0] {
        REG_DATA     = 5'd0,
        REG_DRIVE    = 5'd1,
        REG_VSEL_LO  = 5'd2,
        REG_VSEL_HI  = 5'd3,
        REG_ESEL_LO  = 5'd4,
        REG_ESEL_HI  = 5'd5,
        REG_OPEN     = 5'd6,
        REG_LEVEL    = 5'd7,
        REG_RCV1     = 5'd8,
        REG_RCV2     = 5'd9,
        REG_RCV3     = 5'd10,
        REG_GAP      = 5'd11,
        REG_ISEL1_LO = 5'd12,
        REG_ISEL1_HI = 5'd13,
        REG_ISEL2_LO = 5'd14,
        REG_ISEL2_HI = 5'd15,
        REG_ISEL3_LO = 5'd16,
        REG_ISEL3_HI = 5'd17
    } word_e;

    typedef enum logic [SEL_W-1:0] {
        SRC_LOCAL = 2'd0,
        SRC_ALT1  = 2'd1,
        SRC_ALT2  = 2'd2,
        SRC_ALT3  = 2'd3
    } src_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [DATA_W-1:0] drive;
        logic [DATA_W-1:0] odrain;
        logic [DATA_W-1:0] vsel_lo;
        logic [DATA_W-1:0] vsel_hi;
        logic [DATA_W-1:0] esel_lo;
        logic [DATA_W-1:0] esel_hi;
    } pin_ctrl_t;

    // Bit position of pin n in a one-bit-per-pin word (MSB-first).
    function automatic int pin_bit(input int n);
        return DATA_W - 1 - n;
    endfunction

    // Lowest bit of pin n's two-bit select field within its half word.
    function automatic int sel_lsb(input int n);
        return DATA_W - SEL_W - SEL_W * (n % HALF_PINS);
    endfunction

    // Words that hold software-written state.
    function automatic bit is_storage(input int w);
        return (w != int'(REG_LEVEL)) && (w != int'(REG_GAP));
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= din;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= '0;
            else     chain[s] <= chain[s-1];
        end
    end

    assign dout = chain[LAST];
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] level,
    output logic [DATA_W-1:0] rdata,
    output pin_ctrl_t         ctrl
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]  idx;
    logic [1:0]        unused_byte_lane;
    logic [DATA_W-1:0] store [NUM_WORDS];

    assign idx              = addr[ADDR_W-1:2];
    assign unused_byte_lane = addr[1:0];

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        if (is_storage(w)) begin : g_rw
            always_ff @(posedge clk) begin
                if (rst)
                    store[w] <= '0;
                else if (wr && (idx == IDX_W'(w)))
                    store[w] <= wdata;
            end
        end else begin : g_ro
            assign store[w] = '0;
        end
    end

    always_comb begin
        rdata = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (idx == IDX_W'(w)) begin
                rdata = (w == int'(REG_LEVEL)) ? level : store[w];
            end
        end
    end

    always_comb begin
        ctrl.data    = store[REG_DATA];
        ctrl.drive   = store[REG_DRIVE];
        ctrl.odrain  = store[REG_OPEN];
        ctrl.vsel_lo = store[REG_VSEL_LO];
        ctrl.vsel_hi = store[REG_VSEL_HI];
        ctrl.esel_lo = store[REG_ESEL_LO];
        ctrl.esel_hi = store[REG_ESEL_HI];
    end
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
    import gpio_pkg::*;
(
    input  pin_ctrl_t                      ctrl,
    input  logic [NUM_ALT-1:0][DATA_W-1:0] alt_val,
    input  logic [NUM_ALT-1:0][DATA_W-1:0] alt_en,
    output logic [DATA_W-1:0]              pin_out,
    output logic [DATA_W-1:0]              pin_oe
);
    for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
        localparam int B   = pin_bit(n);
        localparam int LSB = sel_lsb(n);

        src_e vcode, ecode;
        logic val, en;

        if (n < HALF_PINS) begin : g_lo
            assign vcode = src_e'(ctrl.vsel_lo[LSB +: SEL_W]);
            assign ecode = src_e'(ctrl.esel_lo[LSB +: SEL_W]);
        end else begin : g_hi
            assign vcode = src_e'(ctrl.vsel_hi[LSB +: SEL_W]);
            assign ecode = src_e'(ctrl.esel_hi[LSB +: SEL_W]);
        end

        always_comb begin
            unique case (vcode)
                SRC_LOCAL: val = ctrl.data[B];
                SRC_ALT1:  val = alt_val[0][B];
                SRC_ALT2:  val = alt_val[1][B];
                default:   val = alt_val[2][B];
            endcase
            unique case (ecode)
                SRC_LOCAL: en = ctrl.drive[B];
                SRC_ALT1:  en = alt_en[0][B];
                SRC_ALT2:  en = alt_en[1][B];
                default:   en = alt_en[2][B];
            endcase
        end

        assign pin_out[B] = ctrl.odrain[B] ? 1'b0 : val;
        assign pin_oe[B]  = ctrl.odrain[B] ? (en & ~val) : en;
    end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           bus_wr,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [DATA_W-1:0]              bus_wdata,
    output logic [DATA_W-1:0]              bus_rdata,
    input  logic [NUM_ALT-1:0][DATA_W-1:0] alt_val,
    input  logic [NUM_ALT-1:0][DATA_W-1:0] alt_en,
    input  logic [DATA_W-1:0]              pin_in,
    output logic [DATA_W-1:0]              pin_out,
    output logic [DATA_W-1:0]              pin_oe
);
    pin_ctrl_t         ctrl;
    logic [DATA_W-1:0] level;

    gpio_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (pin_in),
        .dout (level)
    );

    gpio_regfile #(.ADDR_W(ADDR_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .level (level),
        .rdata (bus_rdata),
        .ctrl  (ctrl)
    );

    gpio_pin_mux u_mux (
        .ctrl    (ctrl),
        .alt_val (alt_val),
        .alt_en  (alt_en),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk
    import gpio_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [DATA_W-1:0] pin_in,
    input logic [DATA_W-1:0] pin_out,
    input logic [DATA_W-1:0] pin_oe,
    input logic [DATA_W-1:0] level,
    input pin_ctrl_t         ctrl
);
    logic [ADDR_W-3:0] idx;
    logic [1:0]        since_rst;

    assign idx = bus_addr[ADDR_W-1:2];

    always_ff @(posedge clk) begin
        if (rst)                 since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    assert_reset_float_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pin_oe == '0 && bus_rdata == '0));

    assert_write_lands_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && idx == (ADDR_W-2)'(REG_DATA)) |=> (ctrl.data == $past(bus_wdata)));

    assert_open_drain_low_R7: assert property (@(posedge clk) disable iff (rst)
        ((ctrl.odrain & pin_out) == '0));

    assert_level_lag_R8: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2) |-> (level == $past(pin_in, 2)));

    assert_gap_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (idx == (ADDR_W-2)'(REG_GAP)) |-> (bus_rdata == '0));
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .level     (level),
    .ctrl      (ctrl)
);

// File: tb/gpio_port_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_port_ctrl_bench;
    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_wr = 1'b0;
    logic [6:0]        bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [2:0][31:0]  alt_val = '0;
    logic [2:0][31:0]  alt_en = '0;
    logic [31:0]       pin_in = '0;
    logic [31:0]       pin_out;
    logic [31:0]       pin_oe;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string cur_req = "R1";

    logic [31:0] m_reg [18];
    logic [31:0] m_s1, m_s2;

    always #2.5 clk = ~clk;

    gpio_port_ctrl u_gpio_port_ctrl (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .alt_val(alt_val),
        .alt_en(alt_en), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(logic [6:0] a);
        int i = int'(a >> 2);
        if (i == 7) return m_s2;
        if (i == 11 || i >= 18) return 32'h0;
        return m_reg[i];
    endfunction

    task automatic compare_all();
        logic [31:0] e_out = '0, e_oe = '0;
        for (int n = 0; n < 32; n++) begin
            logic [31:0] mask = 32'h8000_0000 >> n;
            int sh = 30 - 2 * (n % 16);
            int vc = int'(((n < 16 ? m_reg[2] : m_reg[3]) >> sh) & 32'd3);
            int ec = int'(((n < 16 ? m_reg[4] : m_reg[5]) >> sh) & 32'd3);
            bit v = (vc == 0) ? |(m_reg[0] & mask) : |(alt_val[vc-1] & mask);
            bit e = (ec == 0) ? |(m_reg[1] & mask) : |(alt_en[ec-1] & mask);
            bit od = |(m_reg[6] & mask);
            if (od) begin
                if (e && !v) e_oe |= mask;
            end else begin
                if (e) e_oe |= mask;
                if (v) e_out |= mask;
            end
        end
        check("bus_rdata", bus_rdata, exp_read(bus_addr));
        check("pin_out", pin_out, e_out);
        check("pin_oe", pin_oe, e_oe);
    endtask

    task automatic model_reset();
        for (int i = 0; i < 18; i++) m_reg[i] = '0;
        m_s1 = '0;
        m_s2 = '0;
    endtask

    task automatic step(bit wr, logic [6:0] a, logic [31:0] d);
        bus_wr = wr; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        if (rst) model_reset();
        else begin
            int i = int'(a >> 2);
            if (wr && i < 18 && i != 7 && i != 11) m_reg[i] = d;
            m_s2 = m_s1;
            m_s1 = pin_in;
        end
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr_word(logic [6:0] a, logic [31:0] d);
        step(1'b1, a, d);
    endtask

    task automatic rd_word(logic [6:0] a);
        step(1'b0, a, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        @(negedge clk);
        cur_req = "R1";
        rst = 1'b1;
        step(1'b0, 7'h00, 32'h0);
        step(1'b1, 7'h00, 32'hFFFF_FFFF);
        rst = 1'b0;
        pin_in = 32'hDEAD_BEEF;
        for (int a = 0; a < 80; a += 4) rd_word(7'(a));

        cur_req = "R3";
        for (int a = 0; a < 80; a += 4)
            wr_word(7'(a), 32'hA500_0000 ^ (32'h0101_0101 * a) ^ 32'h0000_5A3C);
        for (int a = 0; a < 80; a += 4) rd_word(7'(a));

        cur_req = "R9";
        wr_word(7'h2C, 32'hFFFF_FFFF);
        rd_word(7'h2C);
        wr_word(7'h4C, 32'h1234_5678);
        wr_word(7'h7C, 32'h1234_5678);
        for (int a = 0; a < 80; a += 4) rd_word(7'(a));

        cur_req = "R10";
        wr_word(7'h03, 32'h0F0F_0F0F);
        rd_word(7'h00);
        rd_word(7'h02);
        rd_word(7'h21);

        cur_req = "R4";
        wr_word(7'h08, 32'h0); wr_word(7'h0C, 32'h0);
        wr_word(7'h10, 32'h0); wr_word(7'h14, 32'h0);
        wr_word(7'h18, 32'h0);
        wr_word(7'h04, 32'hFFFF_0000);
        wr_word(7'h00, 32'hC3C3_C3C3);
        rd_word(7'h04);

        cur_req = "R2";
        wr_word(7'h04, 32'h8000_0001);
        wr_word(7'h00, 32'h8000_0000);
        rd_word(7'h00);

        cur_req = "R5";
        alt_val[0] = 32'hAAAA_AAAA; alt_val[1] = 32'h0F0F_F0F0; alt_val[2] = 32'h1234_5678;
        alt_en[0] = 32'hFFFF_00FF; alt_en[1] = 32'h5555_AAAA; alt_en[2] = 32'h0000_FFFF;
        wr_word(7'h04, 32'hFFFF_FFFF);
        foreach (alt_val[k]) begin
            wr_word(7'h08, 32'h0 - 32'd1 * 0 + (32'h5555_5555 * (k + 1)));
            wr_word(7'h0C, 32'h1B1B_E4E4 >> k);
        end
        wr_word(7'h08, 32'h1B1B_1B1B);
        wr_word(7'h0C, 32'hE4E4_E4E4);

        cur_req = "R6";
        for (int k = 0; k < 4; k++) begin
            wr_word(7'h10, 32'h5555_5555 * k);
            wr_word(7'h14, 32'h6C6C_9393 ^ (32'h1111_1111 * k));
        end

        cur_req = "R7";
        wr_word(7'h18, 32'hFFFF_FFFF);
        wr_word(7'h18, 32'hF0F0_0F0F);
        wr_word(7'h08, 32'h0); wr_word(7'h10, 32'h0);
        wr_word(7'h00, 32'h3333_CCCC);
        wr_word(7'h18, 32'h0);

        cur_req = "R8";
        for (int k = 0; k < 8; k++) begin
            pin_in = 32'h8000_0000 >> (k * 3);
            rd_word(7'h1C);
        end
        wr_word(7'h1C, 32'hFFFF_FFFF);
        rd_word(7'h1C);
        rd_word(7'h1C);

        cur_req = "R3";
        for (int k = 0; k < 400; k++) begin
            pin_in = $urandom;
            alt_val[k % 3] = $urandom;
            alt_en[(k + 1) % 3] = $urandom;
            step(1'($urandom), 7'($urandom % 84), $urandom);
        end

        cur_req = "R1";
        rst = 1'b1;
        step(1'b0, 7'h00, 32'h0);
        rst = 1'b0;
        for (int a = 0; a < 72; a += 4) rd_word(7'(a));

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule